// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block is a watchdog timer that sits on a simple synchronous register bus. A divider first cuts the input clock by a fixed factor, and each divided tick advances a second counter. That second counter expires after a power-of-two number of ticks. The exponent is a read-only field set when the block is built. Software starts and stops the timer through one enable bit in a control register. It keeps the timer from expiring by writing a 16-bit key value into the upper half-word of that register. Any other value written there is ignored.

When the timer expires, the block raises a one-cycle reset request and latches a sticky expiry flag in a status register. A system reset does not clear that flag. Only a power-on reset, or software, can clear it. Both registers have two extra addresses. One sets bits where a 1 is written, and the other clears bits where a 1 is written, so software never needs a read-modify-write. In the cycle right after the enable bit falls, the block drops every bus access.

Top module: `wdt_keyed`

## Requirements
- R1: While `rst_i` or `por_i` is high, and in the first cycle after release, the enable bit reads 0, `bus_rvalid_o` is 0 and `rst_req_o` is 0. `por_i` also clears the expiry flag.
- R2: Register offsets are as follows. The control register is at byte offset 0x00, with its clear alias at 0x04 and its set alias at 0x08. The status register is at 0x10, with its clear alias at 0x14 and its set alias at 0x18. A read accepted at one clock edge returns data on `bus_rdata_o` with `bus_rvalid_o` high during the following cycle only. The control word reads as follows: enable at bit 15, the POST_SEL parameter at bits 12:8, the CLK_SEL parameter at bits 7:6, the WIN_EN parameter at bit 0, and zeros elsewhere.
- R3: A write to offset 0x00 with `bus_be_i[1]` set loads the enable bit from `wdata[15]`. Byte lanes without their enable, and all read-only bits, stay unchanged.
- R4: With `bus_be_i[1]` set, a 1 in `wdata[15]` at 0x08 sets the enable bit and a 1 at 0x04 clears it. A 0 in that bit position leaves the enable bit as it was.
- R5: Once enabled from a zero count, `rst_req_o` goes high for exactly one cycle. This happens after PRE_DIV * 2^POST_SEL rising edges, counted from the edge that wrote the enable. The count then restarts, and the next pulse follows the same interval later.
- R6: While the enable bit is 0, the count holds its value. Enabling again resumes counting from the held value.
- R7: A write to 0x00 with `bus_be_i[3:2]` = 11 and `wdata[31:16]` = KEY (0x5743 by default) restarts the divider and the tick counter from zero at that edge.
- R8: An upper half-word write with any other value leaves both the count and the readable contents unchanged.
- R9: Expiry sets status bit 4 one cycle after the `rst_req_o` pulse. Writing a 1 to bit 4 at 0x14 clears it, and at 0x18 sets it. A write at 0x10 with `bus_be_i[0]` set loads it from `wdata[4]`. Expiry wins over a clear in the same cycle.
- R10: In the cycle right after the enable bit falls, a bus request is dropped. It performs no write and produces no `bus_rvalid_o`.
- R11: `rst_i` alone leaves the expiry flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high system reset |
| por_i | input | 1 | Synchronous active-high power-on reset, also clears the expiry flag |
| bus_req_i | input | 1 | Bus access request, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address, bits 4:2 decoded |
| bus_be_i | input | 4 | Byte enables for the write data |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after an accepted read |
| rst_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
The bench builds the block with POST_SEL = 3 and PRE_DIV = 32. This makes the expiry interval 256 cycles, so the bench can check exact pulse positions, a second period, a paused count and key restarts within a short run. CLK_SEL = 2 and WIN_EN = 1 make the read-only fields nonzero, so any write that disturbs them shows up in readback. The random phase stays under one interval after reset. It issues back-to-back alias, byte-enable and lockout sequences against a bench model of the enable bit and the flag.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

  // Register access kind, decoded from byte address bits 3:2
  typedef enum logic [1:0] {
    ACC_WRITE = 2'b00,
    ACC_CLR   = 2'b01,
    ACC_SET   = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  // Bit positions software relies on
  localparam int EN_BIT    = 15;
  localparam int FLAG_BIT  = 4;
  localparam int PS_LSB    = 8;
  localparam int PS_W      = 5;
  localparam int CS_LSB    = 6;
  localparam int CS_W      = 2;
  localparam int WIN_BIT   = 0;
  localparam int DATA_W    = 32;
  localparam int HALF_W    = 16;

endpackage

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
  parameter int PRE_DIV  = 32,
  parameter int POST_SEL = 20
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic restart_i,
  output logic expire_o
);

  localparam int PRE_W  = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int POST_W = POST_SEL + 1;
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(PRE_DIV - 1);
  localparam logic [POST_W-1:0] POST_LAST = POST_W'((64'd1 << POST_SEL) - 64'd1);

  logic [PRE_W-1:0]  pre_q;
  logic [POST_W-1:0] post_q;
  logic              expire_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pre_q    <= '0;
      post_q   <= '0;
      expire_q <= 1'b0;
    end else if (restart_i) begin
      pre_q    <= '0;
      post_q   <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (en_i) begin
        if (pre_q == PRE_LAST) begin
          pre_q <= '0;
          if (post_q == POST_LAST) begin
            post_q   <= '0;
            expire_q <= 1'b1;
          end else begin
            post_q <= post_q + 1'b1;
          end
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end

  assign expire_o = expire_q;

  // R6: a stopped counter keeps its value
  a_r6_hold_when_off: assert property (@(posedge clk_i) disable iff (rst_i)
    (!en_i && !restart_i) |=> ($stable(pre_q) && $stable(post_q)));

  // R7: the key restarts both stages
  a_r7_restart_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    restart_i |=> (pre_q == '0 && post_q == '0 && !expire_q));

  generate
    if (PRE_DIV > 1 || POST_SEL > 0) begin : g_pulse_chk
      // R5: the request is a single-cycle pulse
      a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        expire_q |=> !expire_q);
    end
  endgenerate

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_keyed_pkg::*;
#(
  parameter int          POST_SEL = 20,
  parameter int          CLK_SEL  = 0,
  parameter bit          WIN_EN   = 1'b0,
  parameter logic [15:0] KEY      = 16'h5743
) (
  input  logic              clk_i,
  input  logic              sys_rst_i,
  input  logic              por_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [2:0]        sel_i,
  input  logic [3:0]        be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              expire_i,
  output logic              en_o,
  output logic              restart_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  localparam logic [PS_W-1:0] PS_FIELD = PS_W'(POST_SEL);
  localparam logic [CS_W-1:0] CS_FIELD = CS_W'(CLK_SEL);

  logic              en_q, en_d;
  logic              lock_q;
  logic              flag_q, flag_d;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic              accept;
  logic              ctrl_hit, stat_hit;
  acc_kind_e         kind;
  logic [DATA_W-1:0] ctrl_word, stat_word;

  assign accept   = req_i && !lock_q && !sys_rst_i;
  assign kind     = acc_kind_e'(sel_i[1:0]);
  assign ctrl_hit = !sel_i[2];
  assign stat_hit = sel_i[2];

  // Enable bit next state
  always_comb begin
    en_d = en_q;
    if (accept && we_i && ctrl_hit && be_i[1]) begin
      unique case (kind)
        ACC_WRITE: en_d = wdata_i[EN_BIT];
        ACC_CLR:   if (wdata_i[EN_BIT]) en_d = 1'b0;
        ACC_SET:   if (wdata_i[EN_BIT]) en_d = 1'b1;
        default:   en_d = en_q;
      endcase
    end
  end

  // Key detection on the upper half-word of the base address
  assign restart_o = accept && we_i && ctrl_hit && (kind == ACC_WRITE) &&
                     (be_i[3:2] == 2'b11) && (wdata_i[DATA_W-1:HALF_W] == KEY);

  // Expiry flag next state; expiry has priority
  always_comb begin
    flag_d = flag_q;
    if (accept && we_i && stat_hit && be_i[0]) begin
      unique case (kind)
        ACC_WRITE: flag_d = wdata_i[FLAG_BIT];
        ACC_CLR:   if (wdata_i[FLAG_BIT]) flag_d = 1'b0;
        ACC_SET:   if (wdata_i[FLAG_BIT]) flag_d = 1'b1;
        default:   flag_d = flag_q;
      endcase
    end
    if (expire_i) flag_d = 1'b1;
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[EN_BIT]                = en_q;
    ctrl_word[PS_LSB +: PS_W]        = PS_FIELD;
    ctrl_word[CS_LSB +: CS_W]        = CS_FIELD;
    ctrl_word[WIN_BIT]               = WIN_EN;
    stat_word = '0;
    stat_word[FLAG_BIT]              = flag_q;
  end

  always_ff @(posedge clk_i) begin
    if (sys_rst_i) begin
      en_q     <= 1'b0;
      lock_q   <= 1'b0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      en_q     <= en_d;
      lock_q   <= en_q && !en_d;
      rvalid_q <= accept && !we_i;
      rdata_q  <= (accept && !we_i) ? (ctrl_hit ? ctrl_word : stat_word) : '0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (por_i) flag_q <= 1'b0;
    else       flag_q <= flag_d;
  end

  assign en_o     = en_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  // R10: an access in the lockout cycle is dropped
  a_r10_lock_drops: assert property (@(posedge clk_i) disable iff (sys_rst_i)
    lock_q |=> (!rvalid_q && $stable(en_q) && !$past(restart_o)));

  // R2: an accepted read answers in the next cycle
  a_r2_read_answers: assert property (@(posedge clk_i) disable iff (sys_rst_i)
    (req_i && !we_i && !lock_q) |=> rvalid_q);

  // R9: expiry always leaves the flag set
  a_r9_expire_flags: assert property (@(posedge clk_i) disable iff (por_i)
    expire_i |=> flag_q);

  // R11: system reset alone keeps the flag
  a_r11_flag_kept: assert property (@(posedge clk_i) disable iff (por_i)
    (sys_rst_i && !expire_i) |=> $stable(flag_q));

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          PRE_DIV  = 32,
  parameter int          POST_SEL = 20,
  parameter int          CLK_SEL  = 0,
  parameter bit          WIN_EN   = 1'b0,
  parameter logic [15:0] KEY      = 16'h5743
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              por_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [3:0]        bus_be_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic              rst_req_o
);

  logic sys_rst;
  logic en;
  logic restart;
  logic expire;

  assign sys_rst = rst_i || por_i;

  wdt_regs #(
    .POST_SEL (POST_SEL),
    .CLK_SEL  (CLK_SEL),
    .WIN_EN   (WIN_EN),
    .KEY      (KEY)
  ) u_regs (
    .clk_i     (clk_i),
    .sys_rst_i (sys_rst),
    .por_i     (por_i),
    .req_i     (bus_req_i),
    .we_i      (bus_we_i),
    .sel_i     (bus_addr_i[4:2]),
    .be_i      (bus_be_i),
    .wdata_i   (bus_wdata_i),
    .expire_i  (expire),
    .en_o      (en),
    .restart_o (restart),
    .rdata_o   (bus_rdata_o),
    .rvalid_o  (bus_rvalid_o)
  );

  wdt_tick_counter #(
    .PRE_DIV  (PRE_DIV),
    .POST_SEL (POST_SEL)
  ) u_count (
    .clk_i     (clk_i),
    .rst_i     (sys_rst),
    .en_i      (en),
    .restart_i (restart),
    .expire_o  (expire)
  );

  assign rst_req_o = expire;

  logic unused_addr;
  assign unused_addr = ^bus_addr_i;

  // R1: no request while held in reset
  a_r1_quiet_in_reset: assert property (@(posedge clk_i)
    sys_rst |=> (!rst_req_o && !bus_rvalid_o));

endmodule

// File: tb/wdt_keyed_tb.sv
module wdt_keyed_tb;

  localparam int PS   = 3;
  localparam int DIV  = 32;
  localparam int TERM = DIV * (1 << PS);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        por = 1'b1;
  logic        req = 1'b0;
  logic        we  = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        rst_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  wdt_keyed #(
    .ADDR_W(8), .PRE_DIV(DIV), .POST_SEL(PS), .CLK_SEL(2), .WIN_EN(1'b1), .KEY(16'h5743)
  ) u_dut (
    .clk_i(clk), .rst_i(rst), .por_i(por), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_be_i(be), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_rvalid_o(rvalid), .rst_req_o(rst_req)
  );

  function automatic logic [31:0] exp_ctrl(input logic on);
    return {16'h0000, on, 2'b00, 5'd3, 2'd2, 5'd0, 1'b1};
  endfunction

  function automatic logic [31:0] exp_stat(input logic f);
    return {27'd0, f, 4'd0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Starts and ends at a falling edge; the access is sampled at the rising edge between
  task automatic bus_wr(input logic [7:0] a, input logic [3:0] b, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; be = b; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d, output logic v);
    req = 1'b1; we = 1'b0; addr = a; be = 4'hF;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    d = rdata; v = rvalid;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic with_por);
    rst = 1'b1; por = with_por;
    idle(3);
    rst = 1'b0; por = 1'b0;
  endtask

  // Records which edge (1-based) first and second show a request pulse
  task automatic watch(input int n, output int first, output int second, output int cnt);
    first = 0; second = 0; cnt = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (rst_req === 1'b1) begin
        cnt++;
        if (cnt == 1) first = k;
        else if (cnt == 2) second = k;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        v;
    int f1, f2, c;
    logic on_m, flag_m, lock_m;

    idle(3);
    rst = 1'b0; por = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rst_req", {31'd0, rst_req}, 32'd0);
    chk("R1 rvalid", {31'd0, rvalid}, 32'd0);
    bus_rd(8'h00, d, v);
    chk("R2 rvalid on read", {31'd0, v}, 32'd1);
    chk("R1 R2 ctrl after reset", d, exp_ctrl(1'b0));
    idle(1);
    chk("R2 rvalid one cycle", {31'd0, rvalid}, 32'd0);
    bus_rd(8'h10, d, v);
    chk("R1 status after por", d, exp_stat(1'b0));

    // R3 plain writes and byte lanes
    bus_wr(8'h00, 4'b0010, 32'h0000_FFFF);
    bus_rd(8'h00, d, v);
    chk("R3 enable by plain write", d, exp_ctrl(1'b1));
    bus_wr(8'h00, 4'b0001, 32'h0000_0000);
    bus_rd(8'h00, d, v);
    chk("R3 lane 0 leaves enable", d, exp_ctrl(1'b1));
    bus_wr(8'h00, 4'b0010, 32'h0000_0000);
    idle(1);
    bus_rd(8'h00, d, v);
    chk("R3 disable by plain write", d, exp_ctrl(1'b0));

    // R4 aliases
    do_reset(1'b0);
    bus_wr(8'h08, 4'b0010, 32'h0000_8000);
    bus_rd(8'h00, d, v);
    chk("R4 set alias", d, exp_ctrl(1'b1));
    bus_wr(8'h04, 4'b0011, 32'h0000_7FFF);
    bus_rd(8'h00, d, v);
    chk("R4 clear alias with zero bit", d, exp_ctrl(1'b1));
    bus_wr(8'h04, 4'b0010, 32'h0000_8000);
    idle(1);
    bus_rd(8'h00, d, v);
    chk("R4 clear alias", d, exp_ctrl(1'b0));
    bus_wr(8'h08, 4'b0010, 32'h0000_0000);
    bus_rd(8'h00, d, v);
    chk("R4 set alias with zero bit", d, exp_ctrl(1'b0));

    // R5 expiry interval and period
    do_reset(1'b1);
    bus_wr(8'h00, 4'b0010, 32'h0000_8000);
    watch(2 * TERM + 5, f1, f2, c);
    chk("R5 first pulse edge", f1, TERM);
    chk("R5 second pulse edge", f2, 2 * TERM);
    chk("R5 pulse count", c, 2);
    bus_wr(8'h00, 4'b0010, 32'h0);
    idle(1);
    bus_rd(8'h10, d, v);
    chk("R9 flag after expiry", d, exp_stat(1'b1));

    // R11 flag survives system reset, por clears it
    do_reset(1'b0);
    bus_rd(8'h10, d, v);
    chk("R11 flag kept over rst", d, exp_stat(1'b1));
    do_reset(1'b1);
    bus_rd(8'h10, d, v);
    chk("R1 flag cleared by por", d, exp_stat(1'b0));

    // R9 status access kinds
    bus_wr(8'h18, 4'b0001, 32'h0000_0010);
    bus_rd(8'h10, d, v);
    chk("R9 set alias", d, exp_stat(1'b1));
    bus_wr(8'h14, 4'b0001, 32'h0000_00EF);
    bus_rd(8'h10, d, v);
    chk("R9 clear alias zero bit", d, exp_stat(1'b1));
    bus_wr(8'h14, 4'b0001, 32'h0000_0010);
    bus_rd(8'h10, d, v);
    chk("R9 clear alias", d, exp_stat(1'b0));
    bus_wr(8'h10, 4'b0001, 32'h0000_0010);
    bus_rd(8'h10, d, v);
    chk("R9 plain write one", d, exp_stat(1'b1));
    bus_wr(8'h10, 4'b0010, 32'h0000_0000);
    bus_rd(8'h10, d, v);
    chk("R9 plain write without lane", d, exp_stat(1'b1));
    bus_wr(8'h10, 4'b0001, 32'h0000_0000);
    bus_rd(8'h10, d, v);
    chk("R9 plain write zero", d, exp_stat(1'b0));

    // R6 pause and resume
    do_reset(1'b0);
    bus_wr(8'h00, 4'b0010, 32'h0000_8000);
    idle(99);
    bus_wr(8'h00, 4'b0010, 32'h0);
    watch(50, f1, f2, c);
    chk("R6 no pulse while stopped", c, 0);
    bus_wr(8'h00, 4'b0010, 32'h0000_8000);
    watch(300, f1, f2, c);
    chk("R6 resume from held count", f1, TERM - 100);

    // R7 key restart
    do_reset(1'b0);
    bus_wr(8'h00, 4'b0010, 32'h0000_8000);
    idle(199);
    bus_wr(8'h00, 4'b1100, 32'h5743_0000);
    watch(300, f1, f2, c);
    chk("R7 key restarts count", f1, TERM);
    chk("R7 one pulse in window", c, 1);
    bus_rd(8'h00, d, v);
    chk("R7 key keeps control", d, exp_ctrl(1'b1));

    // R8 wrong key
    do_reset(1'b0);
    bus_wr(8'h00, 4'b0010, 32'h0000_8000);
    idle(99);
    bus_wr(8'h00, 4'b1100, 32'h5744_FFFF);
    watch(200, f1, f2, c);
    chk("R8 wrong key leaves count", f1, TERM - 100);
    bus_rd(8'h00, d, v);
    chk("R8 wrong key leaves contents", d, exp_ctrl(1'b1));

    // R10 lockout after enable falls
    do_reset(1'b0);
    bus_wr(8'h08, 4'b0010, 32'h0000_8000);
    bus_wr(8'h04, 4'b0010, 32'h0000_8000);
    bus_wr(8'h08, 4'b0010, 32'h0000_8000);
    bus_rd(8'h00, d, v);
    chk("R10 write in lockout dropped", d, exp_ctrl(1'b0));
    bus_wr(8'h08, 4'b0010, 32'h0000_8000);
    bus_wr(8'h00, 4'b0010, 32'h0);
    bus_rd(8'h00, d, v);
    chk("R10 read in lockout dropped", {31'd0, v}, 32'd0);
    bus_rd(8'h00, d, v);
    chk("R10 access after lockout", d, exp_ctrl(1'b0));

    // Random back-to-back traffic against a model (stays under one interval)
    do_reset(1'b1);
    void'($urandom(32'd1234));
    on_m = 1'b0; flag_m = 1'b0; lock_m = 1'b0;
    for (int i = 0; i < 120; i++) begin
      logic [2:0]  sel;
      logic [3:0]  rb;
      logic [31:0] rw;
      logic        is_rd, new_on, hit_ctrl;
      sel   = 3'($urandom_range(0, 7));
      rb    = 4'($urandom);
      rw    = $urandom & 32'h0000_FFFF;
      is_rd = ($urandom_range(0, 2) == 0);
      hit_ctrl = !sel[2];
      new_on = on_m;
      if (is_rd) begin
        bus_rd({3'b000, sel, 2'b00}, d, v);
        if (lock_m) begin
          chk("R10 random read dropped", {31'd0, v}, 32'd0);
        end else begin
          chk("R2 random read valid", {31'd0, v}, 32'd1);
          chk("R2 R4 R9 random readback", d, hit_ctrl ? exp_ctrl(on_m) : exp_stat(flag_m));
        end
      end else begin
        bus_wr({3'b000, sel, 2'b00}, rb, rw);
        if (!lock_m) begin
          if (hit_ctrl && rb[1]) begin
            case (sel[1:0])
              2'b00: new_on = rw[15];
              2'b01: if (rw[15]) new_on = 1'b0;
              2'b10: if (rw[15]) new_on = 1'b1;
              default: ;
            endcase
          end
          if (!hit_ctrl && rb[0]) begin
            case (sel[1:0])
              2'b00: flag_m = rw[4];
              2'b01: if (rw[4]) flag_m = 1'b0;
              2'b10: if (rw[4]) flag_m = 1'b1;
              default: ;
            endcase
          end
        end
      end
      lock_m = on_m && !new_on;
      on_m   = new_on;
    end
    idle(1);
    bus_rd(8'h00, d, v);
    chk("R3 R4 random final control", d, exp_ctrl(on_m));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule